// File: doc/BRIEF.md
# Power-of-Two Stride Decomposer

This block takes an unsigned stride of any value and hands it out as a series of one-hot strides. Each one-hot stride is a single power of two. A downstream slide datapath that can only shift by powers of two then applies the full stride in several passes. A load strobe captures a stride. From the next cycle the block presents the highest set bit of that stride as a one-hot value, with a valid flag. Each update strobe retires the bit on display and exposes the next lower set bit. When no bits remain, valid falls.

The block also reports the population count of the loaded stride, which is the number of passes the consumer will need. It finds the leading set bit with a leading-zero count over the remaining stride. It retires the issued bit by XOR-ing it out of the remaining stride.

The load and update inputs are plain strobes, not a valid/ready stream. There is no back-pressure at either edge. The consumer pulses update only after it has used the stride on display. A load always wins over an update in the same cycle.

Top module: `p2_stride_decomposer`

## Requirements
- R1: After reset, `valid_o` is 0, `stride_o` is all zeros and `popc_o` is 0.
- R2: A cycle with `load_i` high stores `stride_i` as the remaining stride. From the next cycle, `stride_o` is the highest set bit of that value, as a one-hot word.
- R3: `stride_o` never has more than one bit set.
- R4: A cycle with `update_i` high, `load_i` low and `valid_o` high clears the bit shown on `stride_o` from the remaining stride. From the next cycle, `stride_o` shows the highest bit still set.
- R5: `valid_o` is 1 exactly when the remaining stride is nonzero. `stride_o` is all zeros whenever `valid_o` is 0.
- R6: `popc_o` equals the number of set bits in the most recently loaded stride. It holds that value until the next load.
- R7: When `load_i` and `update_i` are both high in one cycle, only the load takes effect.
- R8: An update while `valid_o` is 0 changes nothing: `valid_o`, `stride_o` and `popc_o` stay as they were.
- R9: Loading a zero stride gives `valid_o` = 0 and `popc_o` = 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stride_i | input | STRIDE_W | Stride value to decompose |
| load_i | input | 1 | Capture `stride_i` as the new remaining stride |
| update_i | input | 1 | Retire the stride on display and advance |
| stride_o | output | STRIDE_W | Current one-hot stride (zero when not valid) |
| valid_o | output | 1 | A nonzero remaining stride exists |
| popc_o | output | $clog2(STRIDE_W)+1 | Set-bit count of the loaded stride |

## Verification
The bench builds the block 8 bits wide and loads every possible stride value. It walks each one through its full update sequence and compares every one-hot output against the highest power of two not above the remaining value, computed arithmetically. The sweep covers several kinds of value, and each tells a different fault apart:
- Zero shows whether valid tracks emptiness.
- A single bit exposes off-by-one errors in the bit index.
- Dense values such as all ones show whether the XOR retires exactly one bit per pass.

After each sequence an extra update checks that an empty decomposer stays still. A separate collision of load and update mid-sequence confirms that the new value replaces the old one.

// File: rtl/p2d_pkg.sv
package p2d_pkg;
  localparam int DEFAULT_STRIDE_W = 16;

  function automatic int cnt_width(input int w);
    return $clog2(w) + 1;
  endfunction
endpackage

// File: rtl/p2d_lead_zero.sv
module p2d_lead_zero #(
  parameter int W = 16,
  localparam int LZ_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    vec_i,
  output logic [LZ_W-1:0] lz_o,
  output logic            empty_o
);
  always_comb begin
    lz_o    = '0;
    empty_o = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        lz_o    = LZ_W'(W - 1 - i);
        empty_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/p2d_popcount.sv
module p2d_popcount #(
  parameter int W = 16,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/p2_stride_decomposer.sv
module p2_stride_decomposer #(
  parameter int STRIDE_W = p2d_pkg::DEFAULT_STRIDE_W,
  localparam int CNT_W = $clog2(STRIDE_W) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                load_i,
  input  logic                update_i,
  output logic [STRIDE_W-1:0] stride_o,
  output logic                valid_o,
  output logic [CNT_W-1:0]    popc_o
);
  localparam int LZ_W = (STRIDE_W > 1) ? $clog2(STRIDE_W) : 1;

  logic [STRIDE_W-1:0] rem_q;
  logic [CNT_W-1:0]    popc_q;
  logic [CNT_W-1:0]    popc_new;
  logic [LZ_W-1:0]     lz;
  logic                rem_empty;
  logic [STRIDE_W-1:0] onehot;

  p2d_lead_zero #(.W(STRIDE_W)) u_lz (
    .vec_i   (rem_q),
    .lz_o    (lz),
    .empty_o (rem_empty)
  );

  p2d_popcount #(.W(STRIDE_W)) u_pc (
    .vec_i (stride_i),
    .cnt_o (popc_new)
  );

  // One-hot position is the complement of the leading-zero count.
  always_comb begin
    onehot = '0;
    if (!rem_empty) begin
      onehot[STRIDE_W - 1 - int'(lz)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      popc_q <= '0;
    end else if (load_i) begin
      rem_q  <= stride_i;
      popc_q <= popc_new;
    end else if (update_i && !rem_empty) begin
      rem_q <= rem_q ^ onehot;
    end
  end

  assign stride_o = onehot;
  assign valid_o  = !rem_empty;
  assign popc_o   = popc_q;
endmodule

// File: rtl/p2_stride_decomposer_chk.sv
module p2_stride_decomposer_chk #(
  parameter int STRIDE_W = 16,
  localparam int CNT_W = $clog2(STRIDE_W) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [STRIDE_W-1:0] stride_i,
  input logic                load_i,
  input logic                update_i,
  input logic [STRIDE_W-1:0] stride_o,
  input logic                valid_o,
  input logic [CNT_W-1:0]    popc_o
);
  AST_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stride_o)); // R3

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == (stride_o != '0)); // R5

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> popc_o == CNT_W'($countones($past(stride_i)))); // R6

  AST_LOAD_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (stride_o & ~$past(stride_i)) == '0); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !load_i && valid_o) |=> stride_o < $past(stride_o)); // R4

  AST_IDLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !load_i && !valid_o) |=> !valid_o && $stable(popc_o)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(popc_o)); // R6
endmodule

bind p2_stride_decomposer p2_stride_decomposer_chk #(.STRIDE_W(STRIDE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stride_i (stride_i),
  .load_i   (load_i),
  .update_i (update_i),
  .stride_o (stride_o),
  .valid_o  (valid_o),
  .popc_o   (popc_o)
);

// File: tb/sim_p2_stride_decomposer.sv
module sim_p2_stride_decomposer;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int CW = $clog2(W) + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] stride_i = '0;
  logic         load_i = 1'b0;
  logic         update_i = 1'b0;
  logic [W-1:0] stride_o;
  logic         valid_o;
  logic [CW-1:0] popc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  p2_stride_decomposer #(.STRIDE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .stride_i(stride_i), .load_i(load_i),
    .update_i(update_i), .stride_o(stride_o), .valid_o(valid_o), .popc_o(popc_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int top_pow2(input int v);
    int p = 1;
    if (v == 0) return 0;
    while (p * 2 <= v) p = p * 2;
    return p;
  endfunction

  function automatic int ones(input int v);
    int n = 0;
    for (int k = 0; k < W; k++) n += (v >> k) & 1;
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rem;
    int pc;
    tick();
    tick();
    check("R1 valid", int'(valid_o), 0);
    check("R1 stride", int'(stride_o), 0);
    check("R1 popc", int'(popc_o), 0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < (1 << W); v++) begin
      stride_i = W'(v);
      load_i = 1'b1;
      tick();
      load_i = 1'b0;
      pc = ones(v);
      check("R6 popc", int'(popc_o), pc);
      if (v == 0) begin
        check("R9 valid", int'(valid_o), 0);
        check("R9 popc", int'(popc_o), 0);
      end else begin
        check("R2 first", int'(stride_o), top_pow2(v));
      end
      rem = v;
      while (rem != 0) begin
        check("R5 valid", int'(valid_o), 1);
        check("R4 stride", int'(stride_o), top_pow2(rem));
        update_i = 1'b1;
        tick();
        update_i = 1'b0;
        rem = rem ^ top_pow2(rem);
        check("R6 hold", int'(popc_o), pc);
      end
      check("R5 empty valid", int'(valid_o), 0);
      check("R5 empty stride", int'(stride_o), 0);
      update_i = 1'b1;
      tick();
      update_i = 1'b0;
      check("R8 valid", int'(valid_o), 0);
      check("R8 stride", int'(stride_o), 0);
      check("R8 popc", int'(popc_o), pc);
    end

    // Load colliding with update mid-sequence.
    stride_i = 8'hA5;
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    update_i = 1'b1;
    tick();
    check("R4 a5 step", int'(stride_o), 32);
    stride_i = 8'h3C;
    load_i = 1'b1;
    update_i = 1'b1;
    tick();
    load_i = 1'b0;
    update_i = 1'b0;
    check("R7 stride", int'(stride_o), 32);
    check("R7 popc", int'(popc_o), 4);
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
    check("R7 next", int'(stride_o), 16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule